// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Shared-Bus Handoff

This block fetches one 16-bit word at a time from a three-wire serial EEPROM that has a chip select, a serial clock and a single bidirectional data pin. A requester presents an 8-bit word address with a one-cycle request. The reader then takes ownership of the EEPROM from optional on-board logic through a two-signal busy handshake. It runs one complete read frame and returns the assembled word with a one-cycle done strobe. Once the frame is over it releases every pin to high impedance.

The serial clock is the system clock divided by a parameter (32 by default). Each frame sends a start bit and a two-bit read opcode, then the address. The EEPROM answers with a zero dummy bit and 16 data bits, most significant first. There is no sequential read, so every word costs a full frame. The requester (for example a power-up loader that walks the default words at addresses 0x00 to 0x0D and then the resource data from 0x0E) issues one request per word.

The pins are modelled as value/enable pairs, so a pad ring can build the tri-state buffers and the external pull-downs.

Top module: `sprom_word_reader`

## Requirements
- R1: While reset is held and on the first cycle after it, `own_busy`, `rd_done`, `sclk_oe`, `scs_oe` and `sio_oe` are all 0.
- R2: A request seen while the reader is idle raises `own_busy` on the next clock. The address is latched at that edge.
- R3: After a request, the pins stay released until `ext_busy` has been low on GUARD_CYC (2) consecutive clock edges. Any high sample restarts that count. Pin enables rise on the second such edge.
- R4: On taking the bus, the reader drives `scs_o` low for CS_LOW_CYC (8) clocks before raising it. This enforces a minimum chip-select low time between consecutive frames.
- R5: While `scs_o` is high, `sclk_o` makes exactly 28 periods of CLK_DIV (32) clocks. Each period is 16 clocks low followed by 16 clocks high, and the frame starts with `sclk_o` low.
- R6: The first 11 serial bits sent on `sio_o` are 1, 1, 0 and then the address MSB first. Each bit changes only while `sclk_o` is low, so it is launched at a falling edge and stable at the next rising edge.
- R7: From the 12th serial period (the dummy bit) to the end of the frame, `sio_oe` is 0, so the EEPROM drives the line. During the first 11 periods `sio_oe` is 1.
- R8: `sio_i` is sampled at the 13th through 28th rising serial-clock edges. These samples form `rd_word` MSB first. `rd_done` is high for exactly one clock.
- R9: In the cycle `rd_done` is high, `own_busy` and all three pin enables are already 0.
- R10: A request made while the reader is not idle is ignored. It starts no frame and does not change the returned word.
- R11: `rd_word` changes only in a cycle where `rd_done` is high, and it holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | One-cycle read request, honoured only when idle |
| rd_addr | input | 8 | Word address for the request |
| rd_done | output | 1 | One-cycle strobe: `rd_word` is valid |
| rd_word | output | 16 | Last word read |
| ext_busy | input | 1 | High while on-board logic uses the EEPROM |
| own_busy | output | 1 | High while the reader wants or owns the EEPROM |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Serial clock drive enable |
| scs_o | output | 1 | Chip select value |
| scs_oe | output | 1 | Chip select drive enable |
| sio_o | output | 1 | Data pin output value |
| sio_oe | output | 1 | Data pin drive enable |
| sio_i | input | 1 | Data pin input value |

## Verification
A corrupted serial-period counter shows at the pins within one frame. The frame then has a wrong number of clock periods, or the data pin is released at the wrong bit. The EEPROM model then returns bits shifted by one or more places, and the returned word no longer matches the expected value for its address. A bad handoff counter drives the pins while external logic still holds its busy line, or sooner than two clean samples allow. That is visible at the enables within two clocks. A stuck state register leaves `own_busy` high after the done strobe, or starts a second frame after an ignored request.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LEAD  = 2'd2,
    ST_FRAME = 2'd3
  } rd_state_e;

  // serial periods in one frame: start + 2 opcode + address + dummy + data
  function automatic int frame_slots(input int aw, input int dw);
    return 3 + aw + 1 + dw;
  endfunction

  // value launched on the data pin in serial period 'slot'
  function automatic logic cmd_bit(input int slot, input int aw, input logic [15:0] addr);
    if (slot < 2)            return 1'b1;
    else if (slot == 2)      return 1'b0;
    else if (slot < 3 + aw)  return addr[aw + 2 - slot];
    return 1'b0;
  endfunction

endpackage

// File: rtl/sprom_sclk_gen.sv
module sprom_sclk_gen #(
  parameter int DIV   = 32,
  parameter int SLOTS = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  output logic [$clog2(DIV)-1:0]   phase,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic                     sclk,
  output logic                     rise_next,
  output logic                     frame_last
);
  localparam int PH_W = $clog2(DIV);
  localparam int SL_W = $clog2(SLOTS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);
  localparam logic [PH_W-1:0] PH_PRE  = PH_W'(DIV / 2 - 1);
  localparam logic [SL_W-1:0] SL_LAST = SL_W'(SLOTS - 1);

  logic period_end;
  assign period_end = run && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= '0;
      slot  <= '0;
    end else if (period_end) begin
      phase <= '0;
      slot  <= (slot == SL_LAST) ? '0 : slot + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign sclk       = run && (phase >= PH_HALF);
  assign rise_next  = run && (phase == PH_PRE);
  assign frame_last = period_end && (slot == SL_LAST);

  p_slot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (int'(slot) < SLOTS));

  p_idle_counters_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase == '0 && slot == '0) || run);

endmodule

// File: rtl/sprom_handoff.sv
module sprom_handoff #(
  parameter int GUARD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic ext_busy,
  output logic grant
);
  localparam int CW = $clog2(GUARD + 1);
  localparam logic [CW-1:0] C_LAST = CW'(GUARD - 1);

  logic [CW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !want || ext_busy) quiet_q <= '0;
    else if (!grant)                 quiet_q <= quiet_q + 1'b1;
  end

  assign grant = want && !ext_busy && (quiet_q == C_LAST);

  p_grant_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !ext_busy);

  p_grant_history_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && GUARD >= 2) |-> !$past(ext_busy));

endmodule

// File: rtl/sprom_word_capture.sv
module sprom_word_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          sio_in,
  input  logic          finish,
  output logic [DW-1:0] word,
  output logic          done
);
  logic [DW-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      word    <= '0;
      done    <= 1'b0;
    end else begin
      if (sample) shift_q <= {shift_q[DW-2:0], sio_in};
      done <= finish;
      if (finish) word <= shift_q;
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(word));

endmodule

// File: rtl/sprom_word_reader.sv
module sprom_word_reader
  import sprom_pkg::*;
#(
  parameter int CLK_DIV    = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int CS_LOW_CYC = 8,
  parameter int GUARD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_word,
  input  logic              ext_busy,
  output logic              own_busy,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              scs_o,
  output logic              scs_oe,
  output logic              sio_o,
  output logic              sio_oe,
  input  logic              sio_i
);
  localparam int CMD_SLOTS   = 3 + ADDR_W;
  localparam int FRAME_SLOTS = frame_slots(ADDR_W, DATA_W);
  localparam int PH_W        = $clog2(CLK_DIV);
  localparam int SL_W        = $clog2(FRAME_SLOTS);
  localparam int LD_W        = $clog2(CS_LOW_CYC + 1);
  localparam logic [LD_W-1:0] LD_LAST = LD_W'(CS_LOW_CYC - 1);

  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LD_W-1:0]   lead_q;

  logic [PH_W-1:0] phase;
  logic [SL_W-1:0] slot;
  logic gen_sclk, rise_next, frame_last, grant;

  // named internal events
  logic in_frame, in_wait, pins_drv, cmd_phase, sample_evt;
  assign in_frame   = (state_q == ST_FRAME);
  assign in_wait    = (state_q == ST_WAIT);
  assign pins_drv   = (state_q == ST_LEAD) || in_frame;
  assign cmd_phase  = in_frame && (int'(slot) < CMD_SLOTS);
  assign sample_evt = rise_next && (int'(slot) > CMD_SLOTS);

  sprom_handoff #(.GUARD(GUARD_CYC)) u_handoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .want     (in_wait),
    .ext_busy (ext_busy),
    .grant    (grant)
  );

  sprom_sclk_gen #(.DIV(CLK_DIV), .SLOTS(FRAME_SLOTS)) u_sclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (in_frame),
    .phase      (phase),
    .slot       (slot),
    .sclk       (gen_sclk),
    .rise_next  (rise_next),
    .frame_last (frame_last)
  );

  sprom_word_capture #(.DW(DATA_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (sample_evt),
    .sio_in (sio_i),
    .finish (frame_last),
    .word   (rd_word),
    .done   (rd_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      lead_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rd_req) begin
          addr_q  <= rd_addr;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          lead_q <= '0;
          if (grant) state_q <= ST_LEAD;
        end
        ST_LEAD: begin
          if (lead_q == LD_LAST) state_q <= ST_FRAME;
          else                   lead_q  <= lead_q + 1'b1;
        end
        ST_FRAME: if (frame_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign own_busy = (state_q != ST_IDLE);
  assign sclk_oe  = pins_drv;
  assign scs_oe   = pins_drv;
  assign sio_oe   = pins_drv && !(in_frame && !cmd_phase);
  assign sclk_o   = gen_sclk;
  assign scs_o    = in_frame;
  assign sio_o    = cmd_phase ? cmd_bit(int'(slot), ADDR_W, 16'(addr_q)) : 1'b0;

  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !own_busy |-> (!sclk_oe && !scs_oe && !sio_oe));

  p_sio_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scs_o && !cmd_phase) |-> !sio_oe);

  p_cs_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scs_o) |-> ($past(scs_oe) && !$past(scs_o)));

  p_sclk_low_at_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scs_o) |-> !sclk_o);

  p_bit_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o) && sio_oe) |-> $stable(sio_o));

  p_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    own_busy |=> $stable(addr_q));

  p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !own_busy);

endmodule

// File: tb/sprom_word_reader_tb.sv
module sprom_word_reader_tb;
  localparam int DIV = 32;
  localparam int CSL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0;
  logic [7:0] rd_addr = '0;
  logic rd_done;
  logic [15:0] rd_word;
  logic ext_busy = 1'b0;
  logic own_busy, sclk_o, sclk_oe, scs_o, scs_oe, sio_o, sio_oe;
  logic sio_i = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sprom_word_reader u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_word(rd_word), .ext_busy(ext_busy),
    .own_busy(own_busy), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .scs_o(scs_o), .scs_oe(scs_oe), .sio_o(sio_o), .sio_oe(sio_oe),
    .sio_i(sio_i)
  );

  function automatic logic [15:0] exp_word(input logic [7:0] a);
    return {a ^ 8'h5A, ~{a[3:0], a[7:4]}};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // EEPROM model: counts rising serial edges inside a frame
  int m_n = 0;
  logic [10:0] m_cmd = '0;
  logic [15:0] m_data = '0;
  int m_oe_bad = 0;
  always @(posedge sclk_o or posedge scs_o) begin
    if (scs_o && !sclk_o) begin
      m_n = 0;
    end else if (scs_o) begin
      m_n++;
      if (m_n <= 11) begin
        m_cmd = {m_cmd[9:0], sio_o};
        if (!sio_oe) m_oe_bad++;
      end
      #2;
      if (m_n == 11) begin
        m_data = exp_word(m_cmd[7:0]);
        sio_i = 1'b0;
      end else if (m_n >= 12 && m_n <= 27) begin
        sio_i = m_data[27 - m_n];
      end else if (m_n == 28) begin
        sio_i = 1'b0;
      end
    end
  end

  // pin monitor, sampled away from the active edge
  int m_lead, m_hi, m_rise, m_drv, m_badrun, m_run, m_badedge, frames = 0;
  bit m_seen, p_oe, p_scs, p_sclk, p_sio;
  always @(negedge clk) begin
    if (scs_oe && !p_oe) begin
      m_lead = 0; m_hi = 0; m_rise = 0; m_drv = 0;
      m_badrun = 0; m_run = 0; m_badedge = 0; m_seen = 0;
    end
    if (scs_oe && !scs_o && !m_seen) m_lead++;
    if (scs_o && !p_scs) frames++;
    if (scs_o) begin
      m_seen = 1;
      m_hi++;
      if (sio_oe) m_drv++;
      if (sclk_o && !p_sclk) m_rise++;
      if (sclk_o && p_sclk && sio_oe && sio_o != p_sio) m_badedge++;
    end
    if (sclk_o) m_run++;
    else begin
      if (p_sclk && m_run != DIV / 2) m_badrun++;
      m_run = 0;
    end
    p_oe = scs_oe; p_scs = scs_o; p_sclk = sclk_o; p_sio = sio_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rd_done) begin got = 1; break; end
    end
  endtask

  task automatic post_done_checks(input logic [7:0] a);
    check(rd_word == exp_word(a), "R8 word", rd_word, exp_word(a));
    check(m_cmd == {3'b110, a}, "R6 command bits", m_cmd, {3'b110, a});
    check(m_oe_bad == 0, "R7 sio driven in command", m_oe_bad, 0);
    check(!own_busy && !scs_oe && !sclk_oe && !sio_oe, "R9 release at done",
          {own_busy, scs_oe, sclk_oe, sio_oe}, 0);
    check(m_lead == CSL, "R4 cs low lead", m_lead, CSL);
    check(m_hi == 28 * DIV && m_rise == 28, "R5 frame length",
          m_hi * 100 + m_rise, 28 * DIV * 100 + 28);
    check(m_badrun == 0, "R5 sclk high width", m_badrun, 0);
    check(m_badedge == 0, "R6 bit change while sclk high", m_badedge, 0);
    check(m_drv == 11 * DIV, "R7 sio release at dummy", m_drv, 11 * DIV);
    @(negedge clk);
    check(!rd_done, "R8 done width", rd_done, 0);
  endtask

  task automatic do_read(input logic [7:0] a);
    bit got;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    check(own_busy == 1'b1, "R2 busy after request", own_busy, 1);
    wait_done(got);
    check(got, "R8 done seen", got, 1);
    post_done_checks(a);
  endtask

  initial begin
    bit got;
    logic [15:0] held;
    int fr;
    repeat (3) @(negedge clk);
    check(!own_busy && !rd_done && !scs_oe && !sclk_oe && !sio_oe, "R1 in reset",
          {own_busy, rd_done, scs_oe, sclk_oe, sio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!own_busy && !rd_done && !scs_oe && !sclk_oe && !sio_oe, "R1 after reset",
          {own_busy, rd_done, scs_oe, sclk_oe, sio_oe}, 0);

    // handoff with external owner (R2, R3)
    ext_busy = 1'b1;
    rd_req = 1'b1; rd_addr = 8'h33;
    @(negedge clk);
    rd_req = 1'b0;
    check(own_busy, "R2 busy raised", own_busy, 1);
    repeat (20) @(negedge clk);
    check(!scs_oe && !sclk_oe && !sio_oe, "R3 pins held off", {scs_oe, sclk_oe, sio_oe}, 0);
    ext_busy = 1'b0;
    @(negedge clk);
    ext_busy = 1'b1;
    repeat (5) @(negedge clk);
    check(!scs_oe, "R3 blip restarts guard", scs_oe, 0);
    ext_busy = 1'b0;
    @(negedge clk);
    check(!scs_oe, "R3 one quiet edge", scs_oe, 0);
    @(negedge clk);
    check(scs_oe && sclk_oe && sio_oe, "R3 drive after two quiet edges",
          {scs_oe, sclk_oe, sio_oe}, 7);
    wait_done(got);
    check(got, "R8 done seen", got, 1);
    post_done_checks(8'h33);

    // sweep over default-word addresses and corners
    for (int a = 0; a < 16; a++) do_read(8'(a));
    do_read(8'h5A);
    do_read(8'hA5);
    do_read(8'h80);
    do_read(8'hFF);

    // request while busy is ignored (R10), word holds (R11)
    fr = frames;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 8'h21;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (300) @(negedge clk);
    rd_req = 1'b1; rd_addr = 8'h77;
    @(negedge clk);
    rd_req = 1'b0;
    wait_done(got);
    check(got && rd_word == exp_word(8'h21), "R10 busy request ignored",
          rd_word, exp_word(8'h21));
    held = rd_word;
    repeat (200) @(negedge clk);
    check(frames == fr + 1, "R10 no extra frame", frames - fr, 1);
    check(!own_busy, "R10 idle after ignored request", own_busy, 0);
    check(rd_word == held, "R11 word held", rd_word, held);

    finish_run();
  end
endmodule